// File: doc/BRIEF.md
# Wake-Up Event Power-Management Signal Generator

This block latches the causes of wake-up events and turns them into a power-management-event output for the rest of the system. Two single-cycle strobes come in: one reports detected line energy, the other a received wake frame or magic packet. Each strobe sets its own bit of a two-bit status field. The field stays set until software clears it with a write-one-to-clear access, and that clear only takes effect while the device-ready input is high.

A small register port gives access to a control register and the status field. The control register selects four things: pulsed or held indication, output polarity, enable of the external pin, and push-pull or open-drain output type. In pulsed mode a new event drives the output active for a fixed time, 50 ms by default, taken from a clock-cycles-per-millisecond parameter. In held mode the output stays active as long as any status bit is set. An internal interrupt flag follows the status field whatever the pin enable is set to. In open-drain mode the polarity setting has no effect. The block then reports an active-low level and a separate drive-low enable for the pad.

Top module: `pme_event_gen`

## Requirements
- R1: Status bit 0 is set by an energy strobe and status bit 1 by a wake-frame strobe. Status reads at address 1 in rd_data[1:0] as 00 (none), 01 (energy), 10 (wake frame) or 11 (both kinds seen), one cycle after the strobe.
- R2: A write to address 1 clears each status bit whose reg_wdata bit is 1, but only while dev_ready is high. With dev_ready low the write leaves the status unchanged.
- R3: When an event strobe and a clear of the same status bit arrive in the same cycle, the bit ends up set.
- R4: In held mode (control bit 0 = 0) with the enable set (control bit 2 = 1), the output is active whenever the status is nonzero.
- R5: In pulsed mode (control bit 0 = 1) with the enable set, an event makes the output active for exactly PULSE_MS*CYC_PER_MS cycles, starting the cycle after the strobe. An event that arrives while the pulse is running does not restart it, and once the pulse ends the output stays inactive even though the status is still set.
- R6: The output goes inactive the cycle after the status is cleared to 00 or the enable is cleared, and a running pulse is cancelled.
- R7: In push-pull mode (control bit 3 = 0), pme_out is active high when control bit 1 = 1 and active low when it is 0, and pme_od_low stays 0.
- R8: In open-drain mode (control bit 3 = 1), pme_out is active low whatever the polarity bit is, and pme_od_low is 1 exactly when the output is active.
- R9: pme_irq is 1 exactly when the status is nonzero, whatever the enable bit is set to.
- R10: After reset the control bits and the status are 0, pme_out is 1, and pme_od_low and pme_irq are 0.
- R11: The control register reads back at address 0 in rd_data[3:0] as {open-drain, enable, polarity, pulse-mode}, and the upper rd_data bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_energy | input | 1 | Single-cycle energy-detected strobe |
| evt_wake | input | 1 | Single-cycle wake-frame or magic-packet strobe |
| dev_ready | input | 1 | Device ready; allows status clears |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Read data for reg_addr (combinational) |
| pme_out | output | 1 | Power-management-event level |
| pme_od_low | output | 1 | Drive-low enable for an open-drain pad |
| pme_irq | output | 1 | Internal interrupt flag, independent of the pin enable |

## Verification
The assertions assume that each event input is a strobe sampled on one clock edge, and that register writes are single-cycle pulses whose address and data are stable at the edge. The bench drives every input just after the falling edge and holds each strobe for exactly one rising edge. Register writes use one cycle each, with dev_ready set on purpose, so every clear, event and control change happens on a known edge. Simultaneous events and clears appear only in the directed priority case.

// File: rtl/pme_gen_pkg.sv
package pme_gen_pkg;

  // Control register layout, MSB first: open-drain, enable, polarity, pulse mode
  typedef struct packed {
    logic od;
    logic en;
    logic pol;
    logic pulse;
  } pme_ctrl_t;

  localparam int CTRL_W = 4;
  localparam int STAT_W = 2;

  // Pin level for a given active state
  function automatic logic pin_level(input logic act, input logic pol, input logic od);
    if (od) return ~act;
    return pol ? act : ~act;
  endfunction

  // Next status: a clear is honoured only when ready, and a set beats a clear
  function automatic logic [STAT_W-1:0] status_step(
      input logic [STAT_W-1:0] cur,
      input logic [STAT_W-1:0] set,
      input logic [STAT_W-1:0] clr,
      input logic              ready);
    logic [STAT_W-1:0] kill;
    kill = ready ? clr : '0;
    return (cur & ~kill) | set;
  endfunction

  // Pulse length in cycles
  function automatic int pulse_cycles(input int ms, input int cyc_per_ms);
    return ms * cyc_per_ms;
  endfunction

endpackage

// File: rtl/pme_wake_status.sv
module pme_wake_status
  import pme_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_energy,
  input  logic              evt_wake,
  input  logic              clr_req,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              dev_ready,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] status_nxt,
  output logic              evt_any
);

  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;

  assign set_vec = {evt_wake, evt_energy};
  assign clr_vec = clr_req ? clr_mask : '0;
  assign evt_any = |set_vec;

  always_comb begin
    status_nxt = status_step(status, set_vec, clr_vec, dev_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_nxt;
  end

endmodule

// File: rtl/pme_pulse_timer.sv
module pme_pulse_timer #(
  parameter int PULSE_LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic run
);

  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (cancel) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      if (start) begin
        run <= 1'b1;
        cnt <= LOAD;
      end
    end else if (last) begin
      run <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pme_pin_drive.sv
module pme_pin_drive
  import pme_gen_pkg::*;
(
  input  logic act,
  input  logic pol,
  input  logic od,
  output logic pin,
  output logic od_low
);

  always_comb begin
    pin    = pin_level(act, pol, od);
    od_low = od & act;
  end

endmodule

// File: rtl/pme_event_gen.sv
module pme_event_gen
  import pme_gen_pkg::*;
#(
  parameter int CYC_PER_MS = 25000,
  parameter int PULSE_MS   = 50,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_energy,
  input  logic              evt_wake,
  input  logic              dev_ready,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              pme_out,
  output logic              pme_od_low,
  output logic              pme_irq
);

  localparam int PULSE_LEN = pulse_cycles(PULSE_MS, CYC_PER_MS);

  pme_ctrl_t         ctrl;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] status_nxt;
  logic              evt_any;
  logic              ctrl_wr;
  logic              stat_wr;
  logic              pulse_start;
  logic              pulse_cancel;
  logic              pulse_run;
  logic              pme_active;

  assign ctrl_wr = reg_wr & ~reg_addr;
  assign stat_wr = reg_wr &  reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= pme_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  pme_wake_status i_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_energy (evt_energy),
    .evt_wake   (evt_wake),
    .clr_req    (stat_wr),
    .clr_mask   (reg_wdata[STAT_W-1:0]),
    .dev_ready  (dev_ready),
    .status     (status),
    .status_nxt (status_nxt),
    .evt_any    (evt_any)
  );

  // The timer follows the control value that will hold after this edge
  pme_ctrl_t ctrl_nxt;
  assign ctrl_nxt = ctrl_wr ? pme_ctrl_t'(reg_wdata[CTRL_W-1:0]) : ctrl;

  assign pulse_start  = evt_any & ctrl_nxt.pulse & ctrl_nxt.en;
  assign pulse_cancel = ~ctrl_nxt.en | ~ctrl_nxt.pulse | (status_nxt == '0);

  pme_pulse_timer #(.PULSE_LEN(PULSE_LEN)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (pulse_start),
    .cancel (pulse_cancel),
    .run    (pulse_run)
  );

  assign pme_active = ctrl.en & (ctrl.pulse ? pulse_run : (status != '0));

  pme_pin_drive i_drive (
    .act    (pme_active),
    .pol    (ctrl.pol),
    .od     (ctrl.od),
    .pin    (pme_out),
    .od_low (pme_od_low)
  );

  assign pme_irq = |status;

  always_comb begin
    rd_data = '0;
    if (reg_addr) rd_data[STAT_W-1:0] = status;
    else          rd_data[CTRL_W-1:0] = ctrl;
  end

endmodule

// File: rtl/pme_event_gen_chk.sv
module pme_event_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_energy,
  input logic       evt_wake,
  input logic       dev_ready,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [1:0] wmask,
  input logic [1:0] status,
  input logic       ctrl_en,
  input logic       ctrl_pulse,
  input logic       ctrl_od,
  input logic       pulse_run,
  input logic       pme_active,
  input logic       pme_out,
  input logic       pme_od_low,
  input logic       pme_irq
);

  AST_ENERGY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_energy |=> status[0]); // R1

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wake |=> status[1]); // R1

  AST_CLR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && !dev_ready && !evt_energy && !evt_wake) |=> $stable(status)); // R2

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wake && reg_wr && reg_addr && wmask[1] && dev_ready) |=> status[1]); // R3

  AST_HELD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !ctrl_pulse && status != 2'b00) |-> pme_active); // R4

  AST_PULSE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_run |-> (status != 2'b00)); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_en) |-> !pme_active); // R6

  AST_OD_LOW_ONLY_OD: assert property (@(posedge clk) disable iff (!rst_n)
    pme_od_low |-> (ctrl_od && !pme_out)); // R8

  AST_IRQ_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_irq) |-> $past(evt_energy || evt_wake)); // R9

endmodule

bind pme_event_gen pme_event_gen_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_energy (evt_energy),
  .evt_wake   (evt_wake),
  .dev_ready  (dev_ready),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .wmask      (reg_wdata[1:0]),
  .status     (status),
  .ctrl_en    (ctrl.en),
  .ctrl_pulse (ctrl.pulse),
  .ctrl_od    (ctrl.od),
  .pulse_run  (pulse_run),
  .pme_active (pme_active),
  .pme_out    (pme_out),
  .pme_od_low (pme_od_low),
  .pme_irq    (pme_irq)
);

// File: tb/test_pme_event_gen.sv
module test_pme_event_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 2;
  localparam int PMS        = 50;
  localparam int PLEN       = CPM * PMS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_energy = 1'b0;
  logic       evt_wake = 1'b0;
  logic       dev_ready = 1'b1;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_data;
  logic       pme_out, pme_od_low, pme_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pme_event_gen #(.CYC_PER_MS(CPM), .PULSE_MS(PMS), .DATA_W(8)) i_pme_event_gen (
    .clk(clk), .rst_n(rst_n), .evt_energy(evt_energy), .evt_wake(evt_wake),
    .dev_ready(dev_ready), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .pme_out(pme_out),
    .pme_od_low(pme_od_low), .pme_irq(pme_irq)
  );

  // Vector: [10:7] ctrl {od,en,pol,pulse}, [6:5] events {wake,energy},
  //         [4] pme_out, [3] pme_od_low, [2] pme_irq, [1:0] status
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {4'b0100, 2'b01, 1'b0, 1'b0, 1'b1, 2'b01},  // R4 R7 held, active low
    {4'b0110, 2'b10, 1'b1, 1'b0, 1'b1, 2'b10},  // R7 active high
    {4'b0010, 2'b11, 1'b0, 1'b0, 1'b1, 2'b11},  // R9 pin disabled, irq set
    {4'b1110, 2'b01, 1'b0, 1'b1, 1'b1, 2'b01},  // R8 od ignores pol
    {4'b1100, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00},  // R8 od idle
    {4'b0110, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00},  // R7 idle high-active
    {4'b1010, 2'b10, 1'b1, 1'b0, 1'b1, 2'b10},  // R8 od, disabled
    {4'b0000, 2'b11, 1'b1, 1'b0, 1'b1, 2'b11}   // R1 both kinds
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic strobe(input logic w, input logic e);
    evt_wake = w; evt_energy = e;
    cyc();
    evt_wake = 1'b0; evt_energy = 1'b0;
  endtask

  function automatic logic [1:0] rd_stat();
    return rd_data[1:0];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    // R10 reset state
    check("R10 pme_out", {7'd0, pme_out}, 8'd1);
    check("R10 od_low", {7'd0, pme_od_low}, 8'd0);
    check("R10 irq", {7'd0, pme_irq}, 8'd0);
    reg_addr = 1'b0; #1;
    check("R10 ctrl", rd_data, 8'h00);
    reg_addr = 1'b1; #1;
    check("R10 status", rd_data, 8'h00);
    rst_n = 1'b1;
    cyc();

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      dev_ready = 1'b1;
      wr(1'b0, {4'b0, v[10:7]});
      wr(1'b1, 8'h03);
      strobe(v[6], v[5]);
      check($sformatf("R7/R8 out v%0d", i), {7'd0, pme_out}, {7'd0, v[4]});
      check($sformatf("R8 od_low v%0d", i), {7'd0, pme_od_low}, {7'd0, v[3]});
      check($sformatf("R9 irq v%0d", i), {7'd0, pme_irq}, {7'd0, v[2]});
      reg_addr = 1'b1; #1;
      check($sformatf("R1 status v%0d", i), {6'd0, rd_stat()}, {6'd0, v[1:0]});
      reg_addr = 1'b0; #1;
      check($sformatf("R11 ctrl v%0d", i), rd_data, {4'b0, v[10:7]});
    end

    // R2 clear blocked while not ready
    wr(1'b0, 8'h04);
    wr(1'b1, 8'h03);
    strobe(1'b1, 1'b1);
    dev_ready = 1'b0;
    wr(1'b1, 8'h03);
    reg_addr = 1'b1; #1;
    check("R2 clear ignored", {6'd0, rd_stat()}, 8'h03);
    check("R2 pin still active", {7'd0, pme_out}, 8'd0);
    dev_ready = 1'b1;
    wr(1'b1, 8'h01);
    reg_addr = 1'b1; #1;
    check("R2 partial clear", {6'd0, rd_stat()}, 8'h02);

    // R3 set beats clear
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h03; evt_energy = 1'b1;
    cyc();
    reg_wr = 1'b0; evt_energy = 1'b0; reg_wdata = '0;
    reg_addr = 1'b1; #1;
    check("R3 set wins", {6'd0, rd_stat()}, 8'h01);

    // R6 enable cleared in held mode
    wr(1'b0, 8'h00);
    check("R6 disable deasserts", {7'd0, pme_out}, 8'd1);
    check("R9 irq ignores enable", {7'd0, pme_irq}, 8'd1);

    // R5 pulse length and no restart
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h03);
    strobe(1'b0, 1'b1);
    begin
      int n;
      n = 0;
      while (pme_out === 1'b1 && n < 400) begin
        evt_wake = (n == 40);
        n++;
        cyc();
      end
      evt_wake = 1'b0;
      check("R5 pulse length", n[7:0], PLEN[7:0]);
    end
    reg_addr = 1'b1; #1;
    check("R5 status held after pulse", {6'd0, rd_stat()}, 8'h03);
    check("R5 inactive after pulse", {7'd0, pme_out}, 8'd0);

    // R6 status clear cancels pulse
    wr(1'b1, 8'h03);
    strobe(1'b1, 1'b0);
    cyc(); cyc();
    check("R6 pulse running", {7'd0, pme_out}, 8'd1);
    wr(1'b1, 8'h02);
    check("R6 clear cancels", {7'd0, pme_out}, 8'd0);
    cyc();
    check("R6 stays cancelled", {7'd0, pme_out}, 8'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule